// File: doc/BRIEF.md
# Two-Dimensional Parity Error Corrector

This block protects a 64-bit word with a geometric product code. The word is treated as an 8 by 8 grid. The encoder produces one even-parity bit for each row and one for each column. It also produces a corner bit that balances the sixteen row and column bits. These 17 check bits are stored alongside the data by the surrounding logic.

On read, the decoder takes the data word and its 17 check bits and recomputes every parity group. From the pattern of failing groups it decides one of four outcomes:

- Nothing is wrong.
- One data bit is wrong. That bit is inverted where the failing row and failing column cross.
- Only the check bits are damaged.
- The damage cannot be repaired.

The data path of the decoder is combinational. The parameter `OUT_REG` selects either one register stage at the outputs (the default) or a direct connection.

Top module: `twod_par_ecc`

## Requirements
- R1: Data bit index is row*8+col. Check word layout: bits [7:0] hold the parities of rows 0..7, bits [15:8] hold the parities of columns 0..7, and bit 16 is the corner bit. A word whose only set bit is r*8+c encodes to check bits r and 8+c alone.
- R2: Every row group and every column group, each taken together with its own parity bit, holds an even number of ones.
- R3: The corner bit makes the sixteen row and column parity bits plus itself even. A freshly encoded word therefore always has corner bit 0.
- R4: When every recomputed check passes, the decoder passes the data unchanged and all three flags are low.
- R5: When exactly one row check and exactly one column check fail, the data bit at their crossing is inverted and the corrected flag is raised.
- R6: The uncorrectable flag is raised, with the data passed unchanged, in two cases. The first is a failure of two or more rows or of two or more columns. The second is a failure of exactly one row only, or exactly one column only, while the corner group passes.
- R7: The check-bit error flag is raised in two cases. The first is when only the corner group fails. The second is when exactly one row check or exactly one column check fails (not both) together with the corner group. In both cases the data passes unchanged and the other flags stay low.
- R8: At most one of the corrected, uncorrectable and check-bit error flags is high at any time.
- R9: With OUT_REG=1, the decoder outputs appear one clock after their inputs, and reset clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enc_data_i | input | 64 | Word to encode |
| enc_chk_o | output | 17 | Check bits for enc_data_i |
| dec_data_i | input | 64 | Word read back |
| dec_chk_i | input | 17 | Check bits read back |
| dec_data_o | output | 64 | Corrected or passed-through word |
| dec_corr_o | output | 1 | A single data bit was inverted |
| dec_uncorr_o | output | 1 | Error pattern cannot be repaired |
| dec_chk_err_o | output | 1 | Damage confined to check bits |

## Verification
The hardest outcomes to reach are those where a single row or a single column fails on its own. Whether the result is a check-bit error or an uncorrectable pattern then depends only on the corner group. Random data alone never produces these cases. The stimulus therefore injects chosen flips into the check word: a row or column parity bit alone, or such a bit together with the corner bit. Two-bit data flips in the same row, in the same column and in distinct positions cover the multi-failure rules.

// File: rtl/twod_par_pkg.sv
package twod_par_pkg;
  typedef enum logic [1:0] {
    DEC_CLEAN  = 2'd0,
    DEC_FIXED  = 2'd1,
    DEC_CHKERR = 2'd2,
    DEC_FATAL  = 2'd3
  } dec_class_e;
endpackage

// File: rtl/twod_par_gen.sv
module twod_par_gen #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int DW  = ROWS * COLS
) (
  input  logic [DW-1:0]   data_i,
  output logic [ROWS-1:0] row_par_o,
  output logic [COLS-1:0] col_par_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_par_o[r] = ^data_i[r*COLS +: COLS];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] col_bits;
    for (genvar r = 0; r < ROWS; r++) begin : g_pick
      assign col_bits[r] = data_i[r*COLS + c];
    end
    assign col_par_o[c] = ^col_bits;
  end
endmodule

// File: rtl/twod_par_enc.sv
module twod_par_enc #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int DW  = ROWS * COLS,
  localparam int CW  = ROWS + COLS + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] chk_o
);
  logic [ROWS-1:0] row_par;
  logic [COLS-1:0] col_par;

  twod_par_gen #(.ROWS(ROWS), .COLS(COLS)) i_gen (
    .data_i   (data_i),
    .row_par_o(row_par),
    .col_par_o(col_par)
  );

  assign chk_o = {^{col_par, row_par}, col_par, row_par};

  // both halves see the same total data parity
  p_halves_agree_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^chk_o[ROWS-1:0]) == (^chk_o[ROWS+COLS-1:ROWS]));

  p_corner_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_o[CW-1] == 1'b0);
endmodule

// File: rtl/twod_par_dec.sv
module twod_par_dec
  import twod_par_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int DW  = ROWS * COLS,
  localparam int CW  = ROWS + COLS + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] chk_i,
  output logic [DW-1:0] data_o,
  output logic          corr_o,
  output logic          uncorr_o,
  output logic          chk_err_o
);
  logic [ROWS-1:0] row_par, syn_row;
  logic [COLS-1:0] col_par, syn_col;
  logic            syn_k;
  logic            row_none, row_one, col_none, col_one;
  dec_class_e      cls;
  logic [DW-1:0]   flip;

  twod_par_gen #(.ROWS(ROWS), .COLS(COLS)) i_gen (
    .data_i   (data_i),
    .row_par_o(row_par),
    .col_par_o(col_par)
  );

  assign syn_row = row_par ^ chk_i[ROWS-1:0];
  assign syn_col = col_par ^ chk_i[ROWS+COLS-1:ROWS];
  assign syn_k   = ^chk_i;

  assign row_none = (syn_row == '0);
  assign col_none = (syn_col == '0);
  assign row_one  = !row_none && ((syn_row & (syn_row - 1'b1)) == '0);
  assign col_one  = !col_none && ((syn_col & (syn_col - 1'b1)) == '0);

  always_comb begin
    if (row_none && col_none)
      cls = syn_k ? DEC_CHKERR : DEC_CLEAN;
    else if (row_one && col_one)
      cls = DEC_FIXED;
    else if (syn_k && ((row_one && col_none) || (row_none && col_one)))
      cls = DEC_CHKERR;  // lone parity bit flipped
    else
      cls = DEC_FATAL;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_fr
    for (genvar c = 0; c < COLS; c++) begin : g_fc
      assign flip[r*COLS + c] = (cls == DEC_FIXED) & syn_row[r] & syn_col[c];
    end
  end

  assign data_o    = data_i ^ flip;
  assign corr_o    = (cls == DEC_FIXED);
  assign uncorr_o  = (cls == DEC_FATAL);
  assign chk_err_o = (cls == DEC_CHKERR);

  p_clean_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_none && col_none && !syn_k) |-> (data_o == data_i && !corr_o && !uncorr_o && !chk_err_o));

  p_fix_one_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o |-> ($countones(data_o ^ data_i) == 1));

  p_keep_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !corr_o |-> (data_o == data_i));

  p_chk_err_pattern_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_err_o |-> (syn_k && $countones({syn_row, syn_col}) <= 1));

  p_flags_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({corr_o, uncorr_o, chk_err_o}));
endmodule

// File: rtl/twod_par_outreg.sv
module twod_par_outreg #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (OUT_REG) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d_i;
    end
    assign q_o = q;

    p_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (q_o == $past(d_i)));
  end else begin : g_wire
    assign q_o = d_i;
  end
endmodule

// File: rtl/twod_par_ecc.sv
module twod_par_ecc #(
  parameter int ROWS    = 8,
  parameter int COLS    = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int DW     = ROWS * COLS,
  localparam int CW     = ROWS + COLS + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] enc_data_i,
  output logic [CW-1:0] enc_chk_o,
  input  logic [DW-1:0] dec_data_i,
  input  logic [CW-1:0] dec_chk_i,
  output logic [DW-1:0] dec_data_o,
  output logic          dec_corr_o,
  output logic          dec_uncorr_o,
  output logic          dec_chk_err_o
);
  logic [DW-1:0] fix_data;
  logic          fix_corr, fix_uncorr, fix_chk_err;

  twod_par_enc #(.ROWS(ROWS), .COLS(COLS)) i_enc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .data_i(enc_data_i),
    .chk_o (enc_chk_o)
  );

  twod_par_dec #(.ROWS(ROWS), .COLS(COLS)) i_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (dec_data_i),
    .chk_i    (dec_chk_i),
    .data_o   (fix_data),
    .corr_o   (fix_corr),
    .uncorr_o (fix_uncorr),
    .chk_err_o(fix_chk_err)
  );

  twod_par_outreg #(.W(DW + 3), .OUT_REG(OUT_REG)) i_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({fix_data, fix_corr, fix_uncorr, fix_chk_err}),
    .q_o   ({dec_data_o, dec_corr_o, dec_uncorr_o, dec_chk_err_o})
  );
endmodule

// File: tb/test_twod_par_ecc.sv
`timescale 1ns/1ps
module test_twod_par_ecc;
  localparam int DW = 64;
  localparam int CW = 17;
  localparam int K_CLEAN = 0, K_FIXED = 1, K_CHK = 2, K_FATAL = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] enc_data_i = '0;
  logic [CW-1:0] enc_chk_o;
  logic [DW-1:0] dec_data_i = '0;
  logic [CW-1:0] dec_chk_i = '0;
  logic [DW-1:0] dec_data_o;
  logic          dec_corr_o, dec_uncorr_o, dec_chk_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  twod_par_ecc i_twod_par_ecc (
    .clk_i(clk), .rst_ni(rst_ni),
    .enc_data_i(enc_data_i), .enc_chk_o(enc_chk_o),
    .dec_data_i(dec_data_i), .dec_chk_i(dec_chk_i),
    .dec_data_o(dec_data_o), .dec_corr_o(dec_corr_o),
    .dec_uncorr_o(dec_uncorr_o), .dec_chk_err_o(dec_chk_err_o)
  );

  function automatic logic [CW-1:0] model_chk(logic [DW-1:0] d);
    logic [CW-1:0] k = '0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        if (d[r*8+c]) begin
          k[r]   = ~k[r];
          k[8+c] = ~k[8+c];
        end
    k[16] = ^k[15:0];
    return k;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // encode d, corrupt, decode; expected outcome known from injected flips
  task automatic run_vec(logic [DW-1:0] d, logic [DW-1:0] df, logic [CW-1:0] cf, int kind, string req);
    logic [CW-1:0] k;
    @(negedge clk);
    enc_data_i = d;
    #1;
    k = model_chk(d);
    check({req, " R2 R3 encode"}, DW'(enc_chk_o), DW'(k));
    dec_data_i = d ^ df;
    dec_chk_i  = k ^ cf;
    @(negedge clk);
    check({req, " data"}, dec_data_o, (kind == K_FATAL) ? (d ^ df) : d);
    check({req, " R8 flags"}, DW'({dec_corr_o, dec_uncorr_o, dec_chk_err_o}),
          DW'({kind == K_FIXED, kind == K_FATAL, kind == K_CHK}));
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    int a, b, sel;
    void'($urandom(32'h2D0C_517A));
    dec_data_i = 64'hFFFF_0000_FFFF_0000;
    dec_chk_i  = 17'h1_2345;
    repeat (3) @(negedge clk);
    // R9 reset clears the registered outputs
    check("R9 reset data", dec_data_o, '0);
    check("R9 reset flags", DW'({dec_corr_o, dec_uncorr_o, dec_chk_err_o}), '0);
    rst_ni = 1'b1;

    // R1 bit r*8+c maps to row r, col c (bit 10 -> row 1 col 2)
    enc_data_i = 64'd1 << 10;
    #1;
    check("R1 layout bit10", DW'(enc_chk_o), DW'(17'h00402));
    enc_data_i = 64'd1 << 63;
    #1;
    check("R1 layout bit63", DW'(enc_chk_o), DW'(17'h08080));

    run_vec('0, '0, '0, K_CLEAN, "R4 zeros");
    run_vec('1, '0, '0, K_CLEAN, "R4 ones");
    run_vec('0, 64'd1, '0, K_FIXED, "R5 bit0");
    run_vec('1, 64'd1 << 63, '0, K_FIXED, "R5 bit63");
    run_vec(64'hA5A5_5A5A_0F0F_F0F0, '0, 17'h10000, K_CHK, "R7 corner only");
    run_vec(64'h1234_5678_9ABC_DEF0, '0, 17'h00008, K_CHK, "R7 row bit");
    run_vec(64'h1234_5678_9ABC_DEF0, '0, 17'h00800, K_CHK, "R7 col bit");
    run_vec(64'h0, '0, 17'h10004, K_FATAL, "R6 single row only");
    run_vec(64'h0, '0, 17'h14000, K_FATAL, "R6 single col only");
    run_vec(64'hFFFF, 64'h3, '0, K_FATAL, "R6 same row");
    run_vec(64'hFFFF, 64'h101, '0, K_FATAL, "R6 same col");
    run_vec(64'hFFFF, (64'd1 << 9) | (64'd1 << 54), '0, K_FATAL, "R6 two rows two cols");

    for (int i = 0; i < 3000; i++) begin
      d   = {$urandom(), $urandom()};
      a   = $urandom_range(63, 0);
      b   = (a + 1 + $urandom_range(62, 0)) % 64;
      sel = $urandom_range(5, 0);
      case (sel)
        0: run_vec(d, '0, '0, K_CLEAN, "R4 rand");
        1: run_vec(d, 64'd1 << a, '0, K_FIXED, "R5 rand");
        2: run_vec(d, '0, CW'(1) << (a % 16), K_CHK, "R7 rand parity bit");
        3: run_vec(d, (64'd1 << a) | (64'd1 << b), '0, K_FATAL, "R6 rand two bits");
        4: run_vec(d, '0, (CW'(1) << (a % 16)) | 17'h10000, K_FATAL, "R6 rand lone+corner");
        default: run_vec(d, '0, 17'h10000, K_CHK, "R7 rand corner");
      endcase
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule